// File: doc/BRIEF.md
# Store Buffer with Load Bypassing

The block sits between a core's memory request port and a single memory-system port. Stores accepted from the core are written into a small in-order queue. They leave it one at a time, oldest first, whenever the memory port is free. Loads are not held behind this queue. A load is sent to memory straight away, ahead of any waiting store. Its address is also compared against every store still queued. If one matches, the data comes from the queue and memory is not touched, so a load can finish while older stores to other addresses are still waiting.

Every accepted load is answered exactly one cycle after it is accepted. The memory port is assumed to return read data one cycle after it accepts a read. An empty flag reports when every accepted store has reached memory, so that an ordering unit or fence can wait on it.

Top module: `store_bypass_buf`

## Requirements
- R1: After synchronous reset the buffer is empty (`buf_empty` high), `rsp_valid` and `mem_valid` are low, and a store request sees `req_ready` high.
- R2: Buffered stores are written to memory (`mem_valid` high, `mem_we` high) strictly in acceptance order, with the accepted address and data. The oldest waiting store is offered on any cycle in which no load needs the memory port.
- R3: A load that matches no buffered store is driven onto the memory port (`mem_we` low, its address) in the same cycle it is presented. It takes the port even when stores are waiting, and it is accepted exactly when `mem_ready` is high.
- R4: A load whose address matches a buffered store is accepted regardless of `mem_ready`. It is answered from the buffer with `rsp_fwd` high, and no memory read is issued for it.
- R5: When several buffered stores match a load address, the response carries the data of the most recently accepted one.
- R6: `rsp_valid` rises exactly one cycle after each accepted load and at no other time. `rsp_data` then holds the forwarded data, or else `mem_rdata` from that cycle.
- R7: With DEPTH stores buffered, a store request sees `req_ready` low and is not queued. Loads are still accepted under the R3 and R4 rules.
- R8: `buf_empty` is high exactly when no accepted store is waiting to be written, and no store write appears on the memory port while it is high.
- R9: A load that is served by memory while the buffer holds stores to other addresses returns the memory value at once, before those stores drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | DW | Load response data |
| rsp_fwd | output | 1 | Response was taken from the buffer |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = store write, 0 = load read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read is accepted |
| buf_empty | output | 1 | No buffered store pending |

## Verification
The assertions take two things for granted about the inputs. Memory returns read data in the cycle after it accepts a read, and the core keeps its request fields steady within a cycle. The bench's memory model keeps this fixed one-cycle read latency. The bench changes requests and `mem_ready` only at the falling edge. The bench keeps one reference memory that is updated when each store is accepted, which is program order. Every load response, from the buffer or from memory, is compared against that memory. Each store write seen on the memory port is matched against a queue of accepted stores.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_LOAD  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_sel_e;

    function automatic logic req_accept(input logic is_store,
                                        input logic full,
                                        input logic hit,
                                        input logic mem_ready);
        if (is_store)
            return !full;
        return hit || mem_ready;
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [AW-1:0]            push_addr,
    input  logic [DW-1:0]            push_data,
    input  logic                     pop,
    output logic                     full,
    output logic                     empty,
    output logic [DEPTH-1:0]         age_vld,
    output logic [DEPTH-1:0][AW-1:0] age_addr,
    output logic [DEPTH-1:0][DW-1:0] age_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                addr_q[tail_q] <= push_addr;
                data_q[tail_q] <= push_data;
                tail_q         <= tail_q + PW'(1);
            end
            if (pop)
                head_q <= head_q + PW'(1);
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    assign full  = (count_q == CW'(DEPTH));
    assign empty = (count_q == '0);

    // entries presented oldest (index 0) to youngest
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW-1:0] idx;
        assign idx         = head_q + PW'(g);
        assign age_vld[g]  = (CW'(g) < count_q);
        assign age_addr[g] = addr_q[idx];
        assign age_data[g] = data_q[idx];
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/sbuf_match.sv
module sbuf_match #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]         age_vld,
    input  logic [DEPTH-1:0][AW-1:0] age_addr,
    input  logic [DEPTH-1:0][DW-1:0] age_data,
    input  logic [AW-1:0]            ld_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    // later (younger) entries overwrite earlier ones
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_vld[i] && (age_addr[i] == ld_addr)) begin
                hit      = 1'b1;
                hit_data = age_data[i];
            end
        end
    end
endmodule

// File: rtl/sbuf_arb.sv
module sbuf_arb
    import sbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_req,
    input  logic [AW-1:0] ld_addr,
    input  logic          st_pend,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          st_pop
);
    port_sel_e sel;

    always_comb begin
        if (ld_req)       sel = PORT_LOAD;
        else if (st_pend) sel = PORT_DRAIN;
        else              sel = PORT_IDLE;
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (sel)
            PORT_LOAD: begin
                mem_valid = 1'b1;
                mem_addr  = ld_addr;
            end
            PORT_DRAIN: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = st_addr;
                mem_wdata = st_data;
            end
            default: ;
        endcase
    end

    assign st_pop = (sel == PORT_DRAIN) && mem_ready;

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_req |-> !st_pop);
    // R2
    drain_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        st_pop |-> st_pend);

endmodule

// File: rtl/store_bypass_buf.sv
module store_bypass_buf
    import sbuf_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_store,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          buf_empty
);
    logic                     full, empty, hit, push, pop, ld_req, ld_fire;
    logic [DEPTH-1:0]         age_vld;
    logic [DEPTH-1:0][AW-1:0] age_addr;
    logic [DEPTH-1:0][DW-1:0] age_data;
    logic [DW-1:0]            hit_data;
    logic                     rsp_valid_q, fwd_q;
    logic [DW-1:0]            fwd_data_q;

    sbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .push_addr(req_addr),
        .push_data(req_wdata), .pop(pop), .full(full), .empty(empty),
        .age_vld(age_vld), .age_addr(age_addr), .age_data(age_data)
    );

    sbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) match_i (
        .age_vld(age_vld), .age_addr(age_addr), .age_data(age_data),
        .ld_addr(req_addr), .hit(hit), .hit_data(hit_data)
    );

    sbuf_arb #(.AW(AW), .DW(DW)) arb_i (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(req_addr),
        .st_pend(!empty), .st_addr(age_addr[0]), .st_data(age_data[0]),
        .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st_pop(pop)
    );

    assign req_ready = req_accept(req_store, full, hit, mem_ready);
    assign push      = req_valid && req_store && !full;
    assign ld_req    = req_valid && !req_store && !hit;
    assign ld_fire   = req_valid && !req_store && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            fwd_q       <= 1'b0;
            fwd_data_q  <= '0;
        end else begin
            rsp_valid_q <= ld_fire;
            fwd_q       <= ld_fire && hit;
            fwd_data_q  <= hit_data;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_fwd   = rsp_valid_q && fwd_q;
    assign rsp_data  = fwd_q ? fwd_data_q : mem_rdata;
    assign buf_empty = empty;

    // R6
    rsp_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_fire |=> rsp_valid);
    // R6
    rsp_only_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && !req_store));
    // R4
    fwd_no_mem_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && hit) |-> !(mem_valid && !mem_we));
    // R8
    empty_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
        buf_empty |-> !(mem_valid && mem_we));

endmodule

// File: tb/store_bypass_buf_tb_top.sv
module store_bypass_buf_tb_top;
    localparam int AW = 3, DW = 8, DEPTH = 4, NA = 1 << AW;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_store = 0, mem_ready = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, mem_rdata = '0;
    logic req_ready, rsp_valid, rsp_fwd, mem_valid, mem_we, buf_empty;
    logic [DW-1:0] rsp_data, mem_wdata;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    store_bypass_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [NA];
    logic [DW-1:0] mem_model [NA];
    logic [AW-1:0] qa [64];
    logic [DW-1:0] qd [64];
    int qh = 0, qn = 0;
    bit exp_rv = 0, exp_fwd = 0, rd_nv = 0;
    logic [DW-1:0] exp_rd = '0, rd_next = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one cycle: entered and left at a falling edge
    task automatic step(input bit v, input bit st, input int a, input int d, input bit mr);
        int hits;
        bit hit, lf;
        mem_rdata = rd_nv ? rd_next : '0;
        req_valid = v; req_store = st; req_addr = AW'(a); req_wdata = DW'(d); mem_ready = mr;
        #1;
        hits = 0;
        for (int i = 0; i < qn; i++) if (qa[(qh + i) % 64] == AW'(a)) hits++;
        hit = (hits > 0);
        if (exp_rv) begin
            chk("R6 rsp_valid", rsp_valid, 1);
            chk(exp_fwd ? (hits > 1 ? "R5 rsp_data" : "R4 rsp_data") : "R9 rsp_data",
                rsp_data, exp_rd);
            chk("R4 rsp_fwd", rsp_fwd, exp_fwd);
        end else chk("R6 rsp_valid idle", rsp_valid, 0);
        chk("R8 buf_empty", buf_empty, qn == 0);
        if (v && st) chk("R7 store ready", req_ready, qn < DEPTH);
        if (v && !st) chk(qn == DEPTH ? "R7 load ready when full" : "R3 load ready",
                          req_ready, hit || mr);
        if (v && !st && !hit) begin
            chk("R3 load on port", {mem_valid, mem_we, 5'd0, mem_addr}, {1'b1, 1'b0, 5'd0, AW'(a)});
        end else if (qn > 0) begin
            chk("R2 drain addr", {mem_valid, mem_we, 5'd0, mem_addr}, {1'b1, 1'b1, 5'd0, qa[qh]});
            chk("R2 drain data", mem_wdata, qd[qh]);
        end else chk("R8 port idle", mem_valid, 0);
        if (v && !st && hit) chk("R4 no mem read", mem_valid && !mem_we, 0);
        lf = v && !st && req_ready;
        rd_nv = 0;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem_model[mem_addr] = mem_wdata;
                if (qn > 0) begin qh = (qh + 1) % 64; qn--; end
            end else begin
                rd_nv = 1; rd_next = mem_model[mem_addr];
            end
        end
        if (v && st && req_ready) begin
            ref_mem[a] = DW'(d);
            qa[(qh + qn) % 64] = AW'(a); qd[(qh + qn) % 64] = DW'(d); qn++;
        end
        exp_rv = lf;
        if (lf) begin exp_rd = ref_mem[a]; exp_fwd = hit; end
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        for (int i = 0; i < NA; i++) begin
            ref_mem[i] = DW'(i * 3 + 1); mem_model[i] = DW'(i * 3 + 1);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        req_store = 1;
        #1;
        chk("R1 req_ready", req_ready, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_valid", mem_valid, 0);
        @(negedge clk);
        // fill with memory stalled; address 2 written twice
        step(1, 1, 2, 8'h11, 0);
        step(1, 1, 5, 8'h22, 0);
        step(1, 1, 2, 8'h33, 0);
        step(1, 1, 7, 8'h44, 0);
        step(1, 1, 1, 8'h55, 0);   // refused: full
        step(1, 0, 2, 0, 0);       // youngest match
        step(1, 0, 5, 0, 0);
        step(1, 0, 3, 0, 0);       // no match, memory stalled
        step(1, 0, 3, 0, 1);       // goes ahead of full buffer
        step(1, 0, 1, 0, 1);       // refused store never landed
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1);
        for (int a = 0; a < NA; a++) step(1, 0, a, 0, 1);
        for (int a = 0; a < NA; a++) begin
            for (int k = 0; k < DEPTH + 1; k++) step(1, 1, a, a * 16 + k, 0);
            step(1, 0, a, 0, 0);
        end
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1);
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[5:3] % NA, r[15:8], r[6] | r[7]);
        end
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1);
        for (int a = 0; a < NA; a++) step(1, 0, a, 0, 1);
        step(0, 0, 0, 0, 1);
        summary();
    end
endmodule